// File: doc/BRIEF.md
# Variable Range Register Codec

This block translates between a memory-region description and the two register words that hold one variable memory-type range. A region is given as a base page frame, a size in pages and an eight-bit memory type. The encode path turns the region into a base word pair and a mask word pair. The mask is the two's-complement negation of the size, and it carries a valid flag in its low word.

The encode path also checks the request. It rejects a region whose base is not aligned to its size. It reports whether the new words differ from the words currently held in the range, looking only at implemented bits. A zero size produces all-zero words, which is how a range is switched off.

The decode path does the reverse on a supplied word set. It returns base, size and type, or it flags the range as free when the valid flag is clear. When the high part of the mask is not a contiguous run of ones, it repairs the mask and raises a flag. Both paths are combinational. Their results go into an output register and appear with a one-cycle response strobe. The register storage itself and any coordination between processors are outside this block.

Top module: `vrc_codec`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `respValid` high for exactly the following cycle, with `respIsDecode` equal to the sampled `reqOp` (0 = encode, 1 = decode). No response appears without a request.
- R2: Encode, aligned nonzero size: `baseLoOut` is the base page frame shifted left by 12, OR'd with the type in bits 7:0 (bits 11:8 zero). `baseHiOut` holds base frame bits 27:20.
- R3: Encode, aligned nonzero size: with `neg` = 2^28 − size, `maskLoOut` is `neg` shifted left by 12 with bit 11 set as the valid flag. `maskHiOut` holds `neg` bits 27:20.
- R4: Encode with size zero drives all four output words to zero and `alignErr` low. The change flags then compare those zero words against the current words.
- R5: The alignment rule works as follows. Take last = base + size − 1, modulo 2^28. While base ends in 0 and last ends in 1, shift both right. The region is aligned only if the two remaining values are equal. A misaligned nonzero request sets `alignErr`, drives all four words to zero and clears both change flags.
- R6: `baseChanged` is set when the encoded base-low word differs from `baseLoIn` under mask 0xFFFFF0FF, or when the base-high words differ.
- R7: `maskChanged` is set when the encoded mask-low word differs from `maskLoIn` under mask 0xFFFFF800, or when the mask-high words differ.
- R8: Decode with bit 11 of `maskLoIn` clear sets `rangeFree` and reports base, size and type as zero, with `maskRepaired` low.
- R9: Decode with bit 11 set gives `decBase` = {`baseHiIn`, `baseLoIn`[31:12]} and `decType` = `baseLoIn`[7:0], with `rangeFree` low.
- R10: Decode forms raw = {`maskHiIn`, `maskLoIn`[31:12]} (28 bits) and m = raw OR'd with ones in the four guard bits 31:28. `decSize` is the low 28 bits of −m. `maskRepaired` stays low for a mask whose ones are contiguous up to bit 27.
- R11: Decode repair works on a nonzero raw mask. Set every bit from the highest set bit of raw up through bit 31. If that value differs from m, it replaces m in the size computation and `maskRepaired` is set.
- R12: Encode outputs change only on an encode request, and decode outputs change only on a decode request. All of them hold otherwise.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 1 | 0 = encode, 1 = decode |
| regionBase | input | 28 | Base page frame to encode |
| regionSize | input | 28 | Size in pages to encode |
| regionType | input | 8 | Memory type to encode |
| baseLoIn | input | 32 | Current or decoded base-low word |
| baseHiIn | input | 8 | Current or decoded base-high word |
| maskLoIn | input | 32 | Current or decoded mask-low word |
| maskHiIn | input | 8 | Current or decoded mask-high word |
| respValid | output | 1 | Response strobe, one cycle |
| respIsDecode | output | 1 | Kind of the last response |
| baseLoOut | output | 32 | Encoded base-low word |
| baseHiOut | output | 8 | Encoded base-high word |
| maskLoOut | output | 32 | Encoded mask-low word |
| maskHiOut | output | 8 | Encoded mask-high word |
| alignErr | output | 1 | Encode request was misaligned |
| baseChanged | output | 1 | Encoded base differs from current |
| maskChanged | output | 1 | Encoded mask differs from current |
| decBase | output | 28 | Decoded base page frame |
| decSize | output | 28 | Decoded size in pages |
| decType | output | 8 | Decoded memory type |
| rangeFree | output | 1 | Decoded range is unused |
| maskRepaired | output | 1 | Decoded mask needed repair |

## Verification
Every result of this block, encoded words, flags and decoded fields alike, is due one register stage after the rising edge that samples the request. `respValid` is high for only that one cycle. The bench drives each request on a falling edge, lets one rising edge capture it, and reads the outputs on the next falling edge, where `respValid` must be high. Hold behaviour is checked one further cycle later, after a request of the other kind or an idle cycle.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int WORD_W    = 32;
  localparam int VALID_BIT = 11;

  typedef enum logic {
    OP_ENCODE = 1'b0,
    OP_DECODE = 1'b1
  } vrc_op_e;

  typedef struct packed {
    logic loadEnc;
    logic loadDec;
  } vrc_strobe_t;
endpackage

// File: rtl/vrc_align.sv
// Size-alignment test: strip paired trailing zeros of base and trailing
// ones of the last frame, then require the remaining high parts to match.
module vrc_align #(
  parameter int PFN_W = 28
) (
  input  logic [PFN_W-1:0] base,
  input  logic [PFN_W-1:0] size,
  output logic             alignOk
);
  logic [PFN_W-1:0] lastPfn;
  logic [PFN_W-1:0] stripped;

  assign lastPfn = base + size - PFN_W'(1);

  assign stripped[0] = ~base[0] & lastPfn[0];
  for (genvar i = 1; i < PFN_W; i++) begin : g_strip
    assign stripped[i] = stripped[i-1] & ~base[i] & lastPfn[i];
  end

  assign alignOk = (((base ^ lastPfn) & ~stripped) == '0);
endmodule

// File: rtl/vrc_mask_fix.sv
// Extends a raw page-frame mask with ones from its top set bit upward and
// flags when that differs from the mask with only guard bits forced high.
module vrc_mask_fix #(
  parameter int PFN_W   = 28,
  parameter int GUARD_W = 4,
  localparam int CALC_W = PFN_W + GUARD_W
) (
  input  logic [PFN_W-1:0]  rawMask,
  output logic [CALC_W-1:0] fixedMask,
  output logic              repaired
);
  logic [CALC_W-1:0] rawExt;
  logic [CALC_W-1:0] orMask;
  logic [CALC_W-1:0] fillMask;
  logic [CALC_W-1:0] extMask;
  logic [CALC_W:0]   seenAbove;
  logic              needFix;

  assign rawExt = {{GUARD_W{1'b0}}, rawMask};
  assign orMask = {{GUARD_W{1'b1}}, rawMask};

  assign seenAbove[CALC_W] = 1'b0;
  for (genvar i = CALC_W - 1; i >= 0; i--) begin : g_fill
    assign seenAbove[i] = seenAbove[i+1] | rawExt[i];
    assign fillMask[i]  = ~seenAbove[i+1];
  end

  assign extMask   = fillMask | rawExt;
  assign needFix   = (|rawMask) && (extMask != orMask);
  assign fixedMask = needFix ? extMask : orMask;
  assign repaired  = needFix;
endmodule

// File: rtl/vrc_ctrl.sv
module vrc_ctrl
  import vrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOp,
  output vrc_strobe_t strb,
  output logic        respValid,
  output logic        respIsDecode
);
  vrc_op_e opNow;

  assign opNow = vrc_op_e'(reqOp);

  always_comb begin
    strb.loadEnc = reqValid && (opNow == OP_ENCODE);
    strb.loadDec = reqValid && (opNow == OP_DECODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respIsDecode <= 1'b0;
    end else begin
      respValid <= reqValid;
      if (reqValid) respIsDecode <= (opNow == OP_DECODE);
    end
  end
endmodule

// File: rtl/vrc_datapath.sv
module vrc_datapath
  import vrc_pkg::*;
#(
  parameter int PFN_W      = 28,
  parameter int PAGE_SHIFT = 12,
  parameter int TYPE_W     = 8,
  parameter int GUARD_W    = 4,
  localparam int LO_PFN_W  = WORD_W - PAGE_SHIFT,
  localparam int HI_W      = PFN_W - LO_PFN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  vrc_strobe_t       strb,
  input  logic [PFN_W-1:0]  regionBase,
  input  logic [PFN_W-1:0]  regionSize,
  input  logic [TYPE_W-1:0] regionType,
  input  logic [WORD_W-1:0] baseLoIn,
  input  logic [HI_W-1:0]   baseHiIn,
  input  logic [WORD_W-1:0] maskLoIn,
  input  logic [HI_W-1:0]   maskHiIn,
  output logic [WORD_W-1:0] baseLoOut,
  output logic [HI_W-1:0]   baseHiOut,
  output logic [WORD_W-1:0] maskLoOut,
  output logic [HI_W-1:0]   maskHiOut,
  output logic              alignErr,
  output logic              baseChanged,
  output logic              maskChanged,
  output logic [PFN_W-1:0]  decBase,
  output logic [PFN_W-1:0]  decSize,
  output logic [TYPE_W-1:0] decType,
  output logic              rangeFree,
  output logic              maskRepaired
);
  localparam int PAD_W  = PAGE_SHIFT - TYPE_W;
  localparam int CALC_W = PFN_W + GUARD_W;
  localparam logic [WORD_W-1:0] BASE_KEEP =
    {{LO_PFN_W{1'b1}}, {PAD_W{1'b0}}, {TYPE_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK_KEEP =
    {{(LO_PFN_W + 1){1'b1}}, {VALID_BIT{1'b0}}};

  // ---------------- encode path ----------------
  logic [PFN_W-1:0]  negSize;
  logic              alignOk;
  logic              sizeZero;
  logic [WORD_W-1:0] encBaseLo, encMaskLo;
  logic [HI_W-1:0]   encBaseHi, encMaskHi;
  logic              encAlignErr, encBaseChg, encMaskChg;

  assign negSize  = PFN_W'(0) - regionSize;
  assign sizeZero = (regionSize == '0);

  vrc_align #(.PFN_W(PFN_W)) i_align (
    .base    (regionBase),
    .size    (regionSize),
    .alignOk (alignOk)
  );

  always_comb begin
    encBaseLo   = {regionBase[LO_PFN_W-1:0], {PAD_W{1'b0}}, regionType};
    encBaseHi   = regionBase[PFN_W-1:LO_PFN_W];
    encMaskLo   = {negSize[LO_PFN_W-1:0], 1'b1, {VALID_BIT{1'b0}}};
    encMaskHi   = negSize[PFN_W-1:LO_PFN_W];
    encAlignErr = 1'b0;
    if (sizeZero) begin
      encBaseLo = '0;
      encBaseHi = '0;
      encMaskLo = '0;
      encMaskHi = '0;
    end else if (!alignOk) begin
      encBaseLo   = '0;
      encBaseHi   = '0;
      encMaskLo   = '0;
      encMaskHi   = '0;
      encAlignErr = 1'b1;
    end
  end

  always_comb begin
    encBaseChg = !encAlignErr &&
                 ((|((encBaseLo ^ baseLoIn) & BASE_KEEP)) || (encBaseHi != baseHiIn));
    encMaskChg = !encAlignErr &&
                 ((|((encMaskLo ^ maskLoIn) & MASK_KEEP)) || (encMaskHi != maskHiIn));
  end

  // ---------------- decode path ----------------
  logic [PFN_W-1:0]  rawMask;
  logic [CALC_W-1:0] fixedMask;
  logic [CALC_W-1:0] negFixed;
  logic              fixFlag;
  logic              decInUse;
  logic [PFN_W-1:0]  decBaseNxt, decSizeNxt;
  logic [TYPE_W-1:0] decTypeNxt;

  assign rawMask  = {maskHiIn, maskLoIn[WORD_W-1:PAGE_SHIFT]};
  assign decInUse = maskLoIn[VALID_BIT];

  vrc_mask_fix #(.PFN_W(PFN_W), .GUARD_W(GUARD_W)) i_mask_fix (
    .rawMask   (rawMask),
    .fixedMask (fixedMask),
    .repaired  (fixFlag)
  );

  assign negFixed = CALC_W'(0) - fixedMask;

  always_comb begin
    if (decInUse) begin
      decBaseNxt = {baseHiIn, baseLoIn[WORD_W-1:PAGE_SHIFT]};
      decSizeNxt = negFixed[PFN_W-1:0];
      decTypeNxt = baseLoIn[TYPE_W-1:0];
    end else begin
      decBaseNxt = '0;
      decSizeNxt = '0;
      decTypeNxt = '0;
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLoOut   <= '0;
      baseHiOut   <= '0;
      maskLoOut   <= '0;
      maskHiOut   <= '0;
      alignErr    <= 1'b0;
      baseChanged <= 1'b0;
      maskChanged <= 1'b0;
    end else if (strb.loadEnc) begin
      baseLoOut   <= encBaseLo;
      baseHiOut   <= encBaseHi;
      maskLoOut   <= encMaskLo;
      maskHiOut   <= encMaskHi;
      alignErr    <= encAlignErr;
      baseChanged <= encBaseChg;
      maskChanged <= encMaskChg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decBase      <= '0;
      decSize      <= '0;
      decType      <= '0;
      rangeFree    <= 1'b0;
      maskRepaired <= 1'b0;
    end else if (strb.loadDec) begin
      decBase      <= decBaseNxt;
      decSize      <= decSizeNxt;
      decType      <= decTypeNxt;
      rangeFree    <= !decInUse;
      maskRepaired <= decInUse && fixFlag;
    end
  end
endmodule

// File: rtl/vrc_codec.sv
module vrc_codec
  import vrc_pkg::*;
#(
  parameter int PFN_W      = 28,
  parameter int PAGE_SHIFT = 12,
  parameter int TYPE_W     = 8,
  parameter int GUARD_W    = 4,
  localparam int HI_W      = PFN_W - (WORD_W - PAGE_SHIFT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqOp,
  input  logic [PFN_W-1:0]  regionBase,
  input  logic [PFN_W-1:0]  regionSize,
  input  logic [TYPE_W-1:0] regionType,
  input  logic [WORD_W-1:0] baseLoIn,
  input  logic [HI_W-1:0]   baseHiIn,
  input  logic [WORD_W-1:0] maskLoIn,
  input  logic [HI_W-1:0]   maskHiIn,
  output logic              respValid,
  output logic              respIsDecode,
  output logic [WORD_W-1:0] baseLoOut,
  output logic [HI_W-1:0]   baseHiOut,
  output logic [WORD_W-1:0] maskLoOut,
  output logic [HI_W-1:0]   maskHiOut,
  output logic              alignErr,
  output logic              baseChanged,
  output logic              maskChanged,
  output logic [PFN_W-1:0]  decBase,
  output logic [PFN_W-1:0]  decSize,
  output logic [TYPE_W-1:0] decType,
  output logic              rangeFree,
  output logic              maskRepaired
);
  vrc_strobe_t strb;

  vrc_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .strb         (strb),
    .respValid    (respValid),
    .respIsDecode (respIsDecode)
  );

  vrc_datapath #(
    .PFN_W      (PFN_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .TYPE_W     (TYPE_W),
    .GUARD_W    (GUARD_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regionBase   (regionBase),
    .regionSize   (regionSize),
    .regionType   (regionType),
    .baseLoIn     (baseLoIn),
    .baseHiIn     (baseHiIn),
    .maskLoIn     (maskLoIn),
    .maskHiIn     (maskHiIn),
    .baseLoOut    (baseLoOut),
    .baseHiOut    (baseHiOut),
    .maskLoOut    (maskLoOut),
    .maskHiOut    (maskHiOut),
    .alignErr     (alignErr),
    .baseChanged  (baseChanged),
    .maskChanged  (maskChanged),
    .decBase      (decBase),
    .decSize      (decSize),
    .decType      (decType),
    .rangeFree    (rangeFree),
    .maskRepaired (maskRepaired)
  );
endmodule

// File: rtl/vrc_checker.sv
module vrc_checker
  import vrc_pkg::*;
#(
  parameter int PFN_W  = 28,
  parameter int TYPE_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqOp,
  input logic [PFN_W-1:0]  regionSize,
  input logic [WORD_W-1:0] baseLoIn,
  input logic [WORD_W-1:0] maskLoIn,
  input logic              respValid,
  input logic              respIsDecode,
  input logic [WORD_W-1:0] baseLoOut,
  input logic [HI_W-1:0]   baseHiOut,
  input logic [WORD_W-1:0] maskLoOut,
  input logic [HI_W-1:0]   maskHiOut,
  input logic              alignErr,
  input logic              baseChanged,
  input logic              maskChanged,
  input logic [PFN_W-1:0]  decBase,
  input logic [PFN_W-1:0]  decSize,
  input logic [TYPE_W-1:0] decType,
  input logic              rangeFree,
  input logic              maskRepaired
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respValid && respIsDecode == $past(reqOp))); // R1
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R1
  AST_VALID_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqOp && regionSize != '0) |=> (alignErr || maskLoOut[VALID_BIT])); // R3
  AST_ZERO_SIZE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqOp && regionSize == '0) |=>
      (maskLoOut == '0 && maskHiOut == '0 && baseLoOut == '0 && baseHiOut == '0 && !alignErr)); // R4
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (baseLoOut == '0 && maskLoOut == '0 && !baseChanged && !maskChanged)); // R5
  AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp && !maskLoIn[VALID_BIT]) |=>
      (rangeFree && decBase == '0 && decSize == '0 && decType == '0 && !maskRepaired)); // R8
  AST_DEC_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp && maskLoIn[VALID_BIT]) |=>
      (!rangeFree && decType == $past(baseLoIn[TYPE_W-1:0]))); // R9
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqOp) |=> ($stable(baseLoOut) && $stable(maskLoOut) && $stable(alignErr))); // R12
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqOp) |=> ($stable(decBase) && $stable(decSize) && $stable(rangeFree))); // R12
endmodule

bind vrc_codec vrc_checker #(
  .PFN_W  (PFN_W),
  .TYPE_W (TYPE_W),
  .HI_W   (HI_W)
) i_vrc_checker (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqOp        (reqOp),
  .regionSize   (regionSize),
  .baseLoIn     (baseLoIn),
  .maskLoIn     (maskLoIn),
  .respValid    (respValid),
  .respIsDecode (respIsDecode),
  .baseLoOut    (baseLoOut),
  .baseHiOut    (baseHiOut),
  .maskLoOut    (maskLoOut),
  .maskHiOut    (maskHiOut),
  .alignErr     (alignErr),
  .baseChanged  (baseChanged),
  .maskChanged  (maskChanged),
  .decBase      (decBase),
  .decSize      (decSize),
  .decType      (decType),
  .rangeFree    (rangeFree),
  .maskRepaired (maskRepaired)
);

// File: tb/test_vrc_codec.sv
`timescale 1ns/1ps
module test_vrc_codec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqOp = 1'b0;
  logic [27:0] regionBase = '0, regionSize = '0;
  logic [7:0]  regionType = '0;
  logic [31:0] baseLoIn = '0, maskLoIn = '0;
  logic [7:0]  baseHiIn = '0, maskHiIn = '0;
  logic        respValid, respIsDecode, alignErr, baseChanged, maskChanged;
  logic        rangeFree, maskRepaired;
  logic [31:0] baseLoOut, maskLoOut;
  logic [7:0]  baseHiOut, maskHiOut, decType;
  logic [27:0] decBase, decSize;

  int nChecks = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  vrc_codec i_vrc_codec (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .regionBase(regionBase), .regionSize(regionSize), .regionType(regionType),
    .baseLoIn(baseLoIn), .baseHiIn(baseHiIn), .maskLoIn(maskLoIn), .maskHiIn(maskHiIn),
    .respValid(respValid), .respIsDecode(respIsDecode),
    .baseLoOut(baseLoOut), .baseHiOut(baseHiOut), .maskLoOut(maskLoOut), .maskHiOut(maskHiOut),
    .alignErr(alignErr), .baseChanged(baseChanged), .maskChanged(maskChanged),
    .decBase(decBase), .decSize(decSize), .decType(decType),
    .rangeFree(rangeFree), .maskRepaired(maskRepaired)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  function automatic bit mAligned(input logic [27:0] b, input logic [27:0] s);
    logic [27:0] lb = b;
    logic [27:0] la = b + s - 28'd1;
    for (int k = 0; k < 28; k++) begin
      if (!lb[0] && la[0]) begin
        lb = lb >> 1;
        la = la >> 1;
      end
    end
    return lb == la;
  endfunction

  task automatic doEncode(input string tag, input logic [27:0] b, input logic [27:0] s,
                          input logic [7:0] t, input logic [31:0] cbl, input logic [7:0] cbh,
                          input logic [31:0] cml, input logic [7:0] cmh);
    logic [63:0] vb, vm;
    logic [31:0] eBl, eMl;
    logic [7:0]  eBh, eMh;
    logic        eErr, eBc, eMc;
    vb = (64'(b) << 12) | 64'(t);
    vm = ((64'h1000_0000 - 64'(s)) << 12) | 64'h800;
    eBl = vb[31:0]; eBh = vb[39:32]; eMl = vm[31:0]; eMh = vm[39:32]; eErr = 1'b0;
    if (s == 0) begin
      eBl = 0; eBh = 0; eMl = 0; eMh = 0;
    end else if (!mAligned(b, s)) begin
      eBl = 0; eBh = 0; eMl = 0; eMh = 0; eErr = 1'b1;
    end
    eBc = !eErr && ((((eBl ^ cbl) & 32'hFFFF_F0FF) != 0) || eBh != cbh);
    eMc = !eErr && ((((eMl ^ cml) & 32'hFFFF_F800) != 0) || eMh != cmh);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 1'b0;
    regionBase = b; regionSize = s; regionType = t;
    baseLoIn = cbl; baseHiIn = cbh; maskLoIn = cml; maskHiIn = cmh;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R1 respValid"}, 64'(respValid), 64'd1);
    check({tag, " R1 respIsDecode"}, 64'(respIsDecode), 64'd0);
    check({tag, " R2 baseLo"}, 64'(baseLoOut), 64'(eBl));
    check({tag, " R2 baseHi"}, 64'(baseHiOut), 64'(eBh));
    check({tag, " R3 maskLo"}, 64'(maskLoOut), 64'(eMl));
    check({tag, " R3 maskHi"}, 64'(maskHiOut), 64'(eMh));
    check({tag, " R5 alignErr"}, 64'(alignErr), 64'(eErr));
    check({tag, " R6 baseChanged"}, 64'(baseChanged), 64'(eBc));
    check({tag, " R7 maskChanged"}, 64'(maskChanged), 64'(eMc));
  endtask

  task automatic doDecode(input string tag, input logic [31:0] bl, input logic [7:0] bh,
                          input logic [31:0] ml, input logic [7:0] mh);
    logic [27:0] raw;
    logic [31:0] m, tmp, fin;
    logic        rep;
    int          h;
    logic [27:0] eBase, eSize;
    logic [7:0]  eType;
    raw = {mh, ml[31:12]};
    m = 32'hF000_0000 | 32'(raw);
    fin = m; rep = 1'b0; h = 0;
    if (raw != 0) begin
      for (int k = 0; k < 28; k++) if (raw[k]) h = k;
      tmp = 32'(raw) | ~((32'd1 << h) - 32'd1);
      if (tmp != m) begin fin = tmp; rep = 1'b1; end
    end
    eSize = 28'(32'd0 - fin);
    eBase = {bh, bl[31:12]};
    eType = bl[7:0];
    if (!ml[11]) begin eBase = 0; eSize = 0; eType = 0; rep = 1'b0; end
    @(negedge clk);
    reqValid = 1'b1; reqOp = 1'b1;
    baseLoIn = bl; baseHiIn = bh; maskLoIn = ml; maskHiIn = mh;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R1 respValid"}, 64'(respValid), 64'd1);
    check({tag, " R1 respIsDecode"}, 64'(respIsDecode), 64'd1);
    check({tag, " R8 rangeFree"}, 64'(rangeFree), 64'(!ml[11]));
    check({tag, " R9 decBase"}, 64'(decBase), 64'(eBase));
    check({tag, " R9 decType"}, 64'(decType), 64'(eType));
    check({tag, " R10 decSize"}, 64'(decSize), 64'(eSize));
    check({tag, " R11 maskRepaired"}, 64'(maskRepaired), 64'(rep));
  endtask

  // ---- scenarios ----
  task automatic tReset();
    check("R13 respValid", 64'(respValid), 0);
    check("R13 baseLoOut", 64'(baseLoOut), 0);
    check("R13 maskLoOut", 64'(maskLoOut), 0);
    check("R13 decSize", 64'(decSize), 0);
    check("R13 flags", 64'({alignErr, baseChanged, maskChanged, rangeFree, maskRepaired}), 0);
  endtask

  task automatic tEncodeBasic();
    doEncode("enc256", 28'h123_4500, 28'h100, 8'h06, 0, 0, 0, 0);
    check("R2 literal baseLo", 64'(baseLoOut), 64'h3450_0006);
    check("R3 literal maskLo", 64'(maskLoOut), 64'hFFF0_0800);
    check("R3 literal maskHi", 64'(maskHiOut), 64'hFF);
    doEncode("enc1", 28'hABC_DEF5, 28'h1, 8'h01, 0, 0, 0, 0);
    doEncode("encHuge", 28'h800_0000, 28'h800_0000, 8'h05, 0, 0, 0, 0);
  endtask

  task automatic tZeroSize();
    doEncode("R4 zero", 28'h000_1000, 28'h0, 8'h06, 32'h1000_0006, 8'h0, 32'hFFFF_F800, 8'hFF);
  endtask

  task automatic tMisaligned();
    doEncode("R5 mis1", 28'h100, 28'h300, 8'h00, 0, 0, 0, 0);
    doEncode("R5 mis2", 28'h80, 28'h100, 8'h06, 0, 0, 0, 0);
    check("R5 literal alignErr", 64'(alignErr), 1);
    doEncode("R5 ok", 28'h200, 28'h200, 8'h04, 0, 0, 0, 0);
  endtask

  task automatic tChangeDetect();
    doEncode("R6 R7 same-reserved", 28'h000_4000, 28'h1000, 8'h06,
             32'h0400_0F06, 8'h00, 32'hFF00_0FFF, 8'hFF);
    check("R6 reserved bits ignored", 64'(baseChanged), 0);
    check("R7 reserved bits ignored", 64'(maskChanged), 0);
    doEncode("R6 type diff", 28'h000_4000, 28'h1000, 8'h06,
             32'h0400_0001, 8'h00, 32'hFF00_1800, 8'hFF);
    check("R6 literal", 64'(baseChanged), 1);
    check("R7 literal", 64'(maskChanged), 1);
    doEncode("R6 R7 hi diff", 28'h000_4000, 28'h1000, 8'h06,
             32'h0400_0006, 8'h01, 32'hFF00_0800, 8'h7F);
  endtask

  task automatic tDecode();
    doDecode("R8 free", 32'h1234_5606, 8'h12, 32'hFFFF_F000, 8'hFF);
    doDecode("R9 R10 contiguous", 32'h3450_0006, 8'h12, 32'hFFF0_0800, 8'hFF);
    check("R10 literal size", 64'(decSize), 64'h100);
    doDecode("R10 full", 32'h0000_0005, 8'h80, 32'h0000_0800, 8'h80);
    doDecode("R11 top-gap", 32'h0000_1004, 8'h00, 32'hFFFF_F800, 8'h0F);
    check("R11 literal repaired", 64'(maskRepaired), 1);
    check("R11 literal size", 64'(decSize), 1);
    doDecode("R11 holes", 32'h0000_0000, 8'h00, 32'hF0F0_F800, 8'hFF);
  endtask

  task automatic tHold();
    logic [31:0] saveBl, saveMl;
    logic [27:0] saveSz;
    doEncode("R12 prep", 28'h002_0000, 28'h1_0000, 8'h01, 0, 0, 0, 0);
    saveBl = baseLoOut; saveMl = maskLoOut;
    doDecode("R12 dec", 32'h5000_0006, 8'h00, 32'hFFFF_0800, 8'hFF);
    check("R12 enc held baseLo", 64'(baseLoOut), 64'(saveBl));
    check("R12 enc held maskLo", 64'(maskLoOut), 64'(saveMl));
    saveSz = decSize;
    doEncode("R12 enc2", 28'h0, 28'h4, 8'h00, 0, 0, 0, 0);
    check("R12 dec held size", 64'(decSize), 64'(saveSz));
    saveBl = baseLoOut;
    regionBase = 28'h777_0000; regionSize = 28'h1; maskLoIn = 32'h0;
    @(negedge clk);
    check("R1 no resp when idle", 64'(respValid), 0);
    check("R12 idle enc held", 64'(baseLoOut), 64'(saveBl));
    check("R12 idle dec held", 64'(decSize), 64'(saveSz));
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEncodeBasic();
    tZeroSize();
    tMisaligned();
    tChangeDetect();
    tDecode();
    tHold();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule